// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a bank of general-purpose pins. Every pin owns one 32-bit control word on a plain register bus. The word picks the pin's direction, the value it drives, its pull request and how it raises an interrupt. There are five interrupt modes, built from three bits: a high-sense bit, a low-sense bit and an edge-select bit. The bank brings every pin input through a two-stage synchroniser. It compares each synchronised sample with the one before to find edges, and keeps a sticky status bit per pin.

The status bits are gathered into a read-only bank status word. One interrupt output is the OR, over all pins, of status AND enable. The register bus has no wait states and no back-pressure. A write completes in the cycle it is presented. A read returns its data on `bus_rdata` one cycle after the request, and that data holds until the next read.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every control field is 0. All of pin_oe, pin_out, pull_en and pull_up are 0, irq is 0, and the status word reads 0.
- R2: Pin k's control word is at byte address 4*k. It reads back with lo-sense at bit 0, hi-sense at bit 1, edge-select at bit 2, enable at bit 3, status at bit 4, output enable at bit 5, output data at bit 6, input data at bit 7, pull enable at bit 8 and pull-high at bit 9. All other bits are 0. Read data appears one cycle after the read request. Unmapped addresses read 0.
- R3: pin_oe[k], pin_out[k], pull_en[k] and pull_up[k] follow bits 5, 6, 8 and 9 of pin k's word from the cycle after the write.
- R4: Bit 7 of pin k's word returns pin_in[k] as seen through the two-flop synchroniser.
- R5: With edge-select=1, hi-sense alone latches status on a rising edge, lo-sense alone on a falling edge, and both together on either edge.
- R6: With edge-select=0, hi-sense latches status while the input is high, and lo-sense while it is low.
- R7: Writing a control word with bit 4=1 clears that pin's status, and bit 4=0 leaves it unchanged. In a level mode whose level is still present, the status sets again one cycle after the clear. In an edge mode it sets again only on a new edge.
- R8: A pin with output enable=1 never latches status.
- R9: The status word at 0x8C holds pin k's status in bit k. Writes to it have no effect.
- R10: irq is high exactly when some pin has status=1 and enable=1. Status latches even while enable=0.
- R11: A qualifying change on pin_in becomes visible on irq after the third rising clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| pin_in | input | 32 | Raw pad inputs (asynchronous) |
| pin_out | output | 32 | Output data per pin |
| pin_oe | output | 32 | Output enable per pin |
| pull_en | output | 32 | Pull request per pin |
| pull_up | output | 32 | Pull direction per pin, 1 = up |
| irq | output | 1 | Combined bank interrupt |

## Verification
Corrupt per-pin state shows up at two places. The status word and irq expose it three edges after the input change that should, or should not, have caused it. A control readback exposes it one cycle after the read. A wrong priority between clear and set shows at irq within one cycle of the clearing write: a level source that never drops, or an edge source that comes back without a new edge. Randomised rounds cover all 32 pins at once, so a decode slip that lands on the wrong pin shows up in the status word of the same round.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int CTL_W = 32;

  // bit positions in a pin's control word
  localparam int B_LO   = 0;
  localparam int B_HI   = 1;
  localparam int B_EDG  = 2;
  localparam int B_EN   = 3;
  localparam int B_STS  = 4;
  localparam int B_OE   = 5;
  localparam int B_DOUT = 6;
  localparam int B_DIN  = 7;
  localparam int B_PEN  = 8;
  localparam int B_PUP  = 9;

  typedef struct packed {
    logic pup;
    logic pen;
    logic dout;
    logic oe;
    logic en;
    logic edg;
    logic hi;
    logic lo;
  } pin_cfg_t;

  localparam int CFG_W = $bits(pin_cfg_t);

  function automatic pin_cfg_t cfg_from_word(input logic [CTL_W-1:0] w);
    pin_cfg_t c;
    c.lo   = w[B_LO];
    c.hi   = w[B_HI];
    c.edg  = w[B_EDG];
    c.en   = w[B_EN];
    c.oe   = w[B_OE];
    c.dout = w[B_DOUT];
    c.pen  = w[B_PEN];
    c.pup  = w[B_PUP];
    return c;
  endfunction

  function automatic logic [CTL_W-1:0] word_from_cfg(input pin_cfg_t c,
                                                     input logic st,
                                                     input logic din);
    logic [CTL_W-1:0] w;
    w         = '0;
    w[B_LO]   = c.lo;
    w[B_HI]   = c.hi;
    w[B_EDG]  = c.edg;
    w[B_EN]   = c.en;
    w[B_STS]  = st;
    w[B_OE]   = c.oe;
    w[B_DOUT] = c.dout;
    w[B_DIN]  = din;
    w[B_PEN]  = c.pen;
    w[B_PUP]  = c.pup;
    return w;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] smp,
  output logic [W-1:0] smp_prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] smp_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      smp_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      smp_q  <= meta_q;
      prev_q <= smp_q;
    end
  end

  assign smp      = smp_q;
  assign smp_prev = prev_q;
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
  import gpio_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CTL_W-1:0] wr_word,
  input  logic             smp,
  input  logic             smp_prev,
  output pin_cfg_t         cfg,
  output logic             stat
);
  pin_cfg_t cfg_q;
  logic     st_q;
  logic     st_d;
  logic     rise;
  logic     fall;
  logic     hit;
  logic     clr;

  always_comb begin
    rise = smp & ~smp_prev;
    fall = ~smp & smp_prev;
    if (cfg_q.edg)
      hit = (cfg_q.hi & rise) | (cfg_q.lo & fall);
    else
      hit = (cfg_q.hi & smp) | (cfg_q.lo & ~smp);
    if (cfg_q.oe)
      hit = 1'b0;
  end

  assign clr = wr_stb & wr_word[B_STS];

  // edge: a coincident edge beats the clear; level: the clear wins for one cycle
  always_comb begin
    if (cfg_q.edg)
      st_d = (st_q & ~clr) | hit;
    else
      st_d = (st_q | hit) & ~clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      st_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (wr_stb)
        cfg_q <= cfg_from_word(wr_word);
    end
  end

  assign cfg  = cfg_q;
  assign stat = st_q;
endmodule

// File: rtl/gpio_regbus.sv
module gpio_regbus
  import gpio_bank_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 8,
  parameter int STAT_OFS = 'h8C
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [CTL_W-1:0]       bus_wdata,
  output logic [CTL_W-1:0]       bus_rdata,
  output logic [NPINS-1:0]       wr_stb,
  input  logic [NPINS*CFG_W-1:0] cfg_flat,
  input  logic [NPINS-1:0]       stat,
  input  logic [NPINS-1:0]       smp
);
  localparam int IDX_W = $clog2(NPINS);
  localparam int WIN   = 4 * NPINS;

  logic             pin_hit;
  logic             stat_hit;
  logic [IDX_W-1:0] idx;
  logic [CTL_W-1:0] rd_next;
  logic [CTL_W-1:0] rdata_q;

  assign idx      = bus_addr[IDX_W+1:2];
  assign pin_hit  = (bus_addr[1:0] == 2'b00) && (32'(bus_addr) < 32'(WIN));
  assign stat_hit = (32'(bus_addr) == 32'(STAT_OFS));

  for (genvar k = 0; k < NPINS; k++) begin : g_stb
    assign wr_stb[k] = bus_sel & bus_wr & pin_hit & (idx == IDX_W'(k));
  end

  always_comb begin
    rd_next = '0;
    if (pin_hit)
      rd_next = word_from_cfg(pin_cfg_t'(cfg_flat[idx*CFG_W +: CFG_W]),
                              stat[idx], smp[idx]);
    else if (stat_hit)
      rd_next = CTL_W'(stat);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (bus_sel && !bus_wr)
      rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 8,
  parameter int STAT_OFS = 'h8C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTL_W-1:0]  bus_wdata,
  output logic [CTL_W-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_up,
  output logic              irq
);
  logic [NPINS-1:0]       smp;
  logic [NPINS-1:0]       smp_prev;
  logic [NPINS-1:0]       wr_stb;
  logic [NPINS-1:0]       stat_vec;
  logic [NPINS-1:0]       en_vec;
  logic [NPINS-1:0]       edg_vec;
  logic [NPINS*CFG_W-1:0] cfg_flat;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (pin_in),
    .smp      (smp),
    .smp_prev (smp_prev)
  );

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    pin_cfg_t c;
    gpio_pin_unit u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb[k]),
      .wr_word  (bus_wdata),
      .smp      (smp[k]),
      .smp_prev (smp_prev[k]),
      .cfg      (c),
      .stat     (stat_vec[k])
    );
    assign cfg_flat[k*CFG_W +: CFG_W] = c;
    assign pin_oe[k]  = c.oe;
    assign pin_out[k] = c.dout;
    assign pull_en[k] = c.pen;
    assign pull_up[k] = c.pup;
    assign en_vec[k]  = c.en;
    assign edg_vec[k] = c.edg;
  end

  gpio_regbus #(.NPINS(NPINS), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)) u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .wr_stb    (wr_stb),
    .cfg_flat  (cfg_flat),
    .stat      (stat_vec),
    .smp       (smp)
  );

  assign irq = |(stat_vec & en_vec);
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int NPINS    = 32,
  parameter int ADDR_W   = 8,
  parameter int STAT_OFS = 'h8C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NPINS-1:0]  stat,
  input logic [NPINS-1:0]  edg,
  input logic [NPINS-1:0]  pin_oe,
  input logic              irq
);
  localparam int IDX_W = $clog2(NPINS);

  logic             pin_wr;
  logic [IDX_W-1:0] widx;
  assign widx   = bus_addr[IDX_W+1:2];
  assign pin_wr = bus_sel && bus_wr && (bus_addr[1:0] == 2'b00) &&
                  (32'(bus_addr) < 32'(4*NPINS));

  AST_LEVEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_wr && bus_wdata[4] && !edg[widx]) |=> !stat[$past(widx)]); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat) & ~stat) == '0) ||
              $past(bus_sel && bus_wr && bus_wdata[4]))); // R7

  AST_OUTPUT_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & $past(pin_oe)) == '0)); // R8

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (32'(bus_addr) >= 32'(4*NPINS)) &&
     (32'(bus_addr) != 32'(STAT_OFS))) |=> (bus_rdata == '0)); // R2
endmodule

bind gpio_irq_bank gpio_bank_checker #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .stat      (stat_vec),
  .edg       (edg_vec),
  .pin_oe    (pin_oe),
  .irq       (irq)
);

// File: tb/sim_gpio_irq_bank.sv
module sim_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pull_en, pull_up;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pull_en(pull_en), .pull_up(pull_up), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected latch condition from control word w, previous and new input level
  function automatic logic detect(input logic [31:0] w, input logic o, input logic n);
    if (w[5]) return 1'b0;
    if (w[2]) return (w[1] & n & ~o) | (w[0] & ~n & o);
    return (w[1] & n) | (w[0] & ~n);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %h expected %h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] cfg [32];
    logic [31:0] v0, v1, exp_st, en_m;
    void'($urandom(32'd20240611));

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pin_oe", pin_oe, 32'd0);
    check("R1 pin_out", pin_out, 32'd0);
    check("R1 pulls", pull_en | pull_up, 32'd0);
    rd(8'h8C, d); check("R1 status word", d, 32'd0);
    rd(8'h00, d); check("R1 ctl word", d, 32'd0);

    // R3 drive fields, R2 readback of pin 3 at 0x0C
    wr(8'h0C, 32'h360);
    check("R3 pin_oe", pin_oe, 32'h8);
    check("R3 pin_out", pin_out, 32'h8);
    check("R3 pull_en", pull_en, 32'h8);
    check("R3 pull_up", pull_up, 32'h8);
    rd(8'h0C, d); check("R2 readback", d, 32'h360);
    rd(8'h90, d); check("R2 unmapped", d, 32'd0);

    // R4 input data through synchroniser (pin 6)
    pin_in[6] = 1'b1; wait_n(4);
    rd(8'h18, d); check("R4 din", d, 32'h80);

    // R5 rising on pin 5, R11 latency
    wr(8'h14, 32'h0E);
    pin_in[5] = 1'b1;
    wait_n(2); check("R11 not yet", {31'd0, irq}, 32'd0);
    wait_n(1); check("R11 third edge", {31'd0, irq}, 32'd1);
    rd(8'h8C, d); check("R9 status bit5", d, 32'h20);
    wr(8'h14, 32'h1E); check("R7 clear", {31'd0, irq}, 32'd0);
    pin_in[5] = 1'b0; wait_n(4); check("R5 rising ignores fall", {31'd0, irq}, 32'd0);
    pin_in[5] = 1'b1; wait_n(4); check("R7 new edge", {31'd0, irq}, 32'd1);
    wr(8'h14, 32'h0E); check("R7 write0 keeps", {31'd0, irq}, 32'd1);
    wr(8'h14, 32'h10);

    // R5 falling on pin 9
    wr(8'h24, 32'h0D);
    pin_in[9] = 1'b1; wait_n(4); check("R5 falling ignores rise", {31'd0, irq}, 32'd0);
    pin_in[9] = 1'b0; wait_n(4); check("R5 falling", {31'd0, irq}, 32'd1);
    wr(8'h24, 32'h10);

    // R5 both edges on pin 12
    wr(8'h30, 32'h0F);
    pin_in[12] = 1'b1; wait_n(4); check("R5 both rise", {31'd0, irq}, 32'd1);
    wr(8'h30, 32'h1F);
    pin_in[12] = 1'b0; wait_n(4); check("R5 both fall", {31'd0, irq}, 32'd1);
    wr(8'h30, 32'h10);

    // R6 level high on pin 14, R7 re-set after clear
    pin_in[14] = 1'b1; wait_n(4);
    wr(8'h38, 32'h0A); wait_n(1); check("R6 level high", {31'd0, irq}, 32'd1);
    wr(8'h38, 32'h1A); check("R7 level cleared", {31'd0, irq}, 32'd0);
    wait_n(1); check("R7 level re-sets", {31'd0, irq}, 32'd1);
    pin_in[14] = 1'b0; wait_n(4);
    wr(8'h38, 32'h1A); wait_n(2); check("R6 level gone", {31'd0, irq}, 32'd0);
    wr(8'h38, 32'h10);

    // R6 level low on pin 15
    wr(8'h3C, 32'h09); wait_n(1); check("R6 level low", {31'd0, irq}, 32'd1);
    pin_in[15] = 1'b1; wait_n(4);
    wr(8'h3C, 32'h19); wait_n(2); check("R6 low released", {31'd0, irq}, 32'd0);
    wr(8'h3C, 32'h10);

    // R10 status latches while disabled (pin 20)
    wr(8'h50, 32'h06);
    pin_in[20] = 1'b1; wait_n(4);
    check("R10 disabled no irq", {31'd0, irq}, 32'd0);
    rd(8'h8C, d); check("R10 status latched", d, 32'h0010_0000);
    wr(8'h50, 32'h0E); check("R10 enable raises irq", {31'd0, irq}, 32'd1);
    wr(8'h50, 32'h10);

    // R8 output pin never latches (pin 3 level high while driving)
    wr(8'h0C, 32'h36A);
    pin_in[3] = 1'b1; wait_n(4);
    check("R8 output no irq", {31'd0, irq}, 32'd0);
    rd(8'h8C, d); check("R8 output no status", d, 32'd0);

    // R9 write to status word ignored
    wr(8'h8C, 32'hFFFF_FFFF);
    rd(8'h8C, d); check("R9 ro status", d, 32'd0);
    check("R9 no irq", {31'd0, irq}, 32'd0);

    // random rounds over all pins
    for (int r = 0; r < 20; r++) begin
      v0 = $urandom;
      pin_in = v0; wait_n(4);
      en_m = '0; exp_st = '0;
      for (int k = 0; k < 32; k++) begin
        logic [31:0] x;
        x = $urandom;
        cfg[k] = {22'd0, x[9:8], x[6], (x[11:10] == 2'b00), 1'b1, x[3:0]};
        wr(8'(4*k), cfg[k]);
      end
      wait_n(3);
      for (int k = 0; k < 32; k++) begin
        en_m[k] = cfg[k][3];
        exp_st[k] = detect(cfg[k], v0[k], v0[k]);
      end
      v1 = $urandom;
      pin_in = v1; wait_n(4);
      for (int k = 0; k < 32; k++)
        exp_st[k] = exp_st[k] | detect(cfg[k], v0[k], v1[k]);
      rd(8'h8C, d); check("R5/R6 random status", d, exp_st);
      check("R10 random irq", {31'd0, irq}, {31'd0, |(exp_st & en_m)});
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule